// File: doc/BRIEF.md
# Reset-Aware Memory Enable Gate

This block sits between a processor's active-low chip-enable and a battery-backed RAM. While the system runs normally, the incoming enable reaches the memory through a purely combinational path. While the system is held in reset, the gate closes and drives the memory enable inactive (high). This keeps stray writes caused by a collapsing supply or a runaway program out of the protected memory. Battery-backup mode also forces the enable inactive.

A write can be in progress when reset begins. In that case the gate stays open for a limited grace window, so the access can finish instead of being cut in half. The window ends when the processor releases the enable or when a fixed number of microsecond ticks has elapsed, whichever happens first. Once the gate has closed during a reset, it stays closed until reset ends. At that point the output again follows the incoming enable, with no added register stage.

Top module: `ce_guard_top`

## Requirements
- R1: With `resetActive` low and `backupMode` low, `ceOutN` equals `ceInN` in the same cycle (combinational, no register in the path).
- R2: `ceOutN` is low only when `ceInN` is low.
- R3: If `ceInN` is high at the first clock edge that samples `resetActive` high, `ceOutN` is high for the rest of that reset, whatever `ceInN` does.
- R4: If `ceInN` is low at the first clock edge that samples `resetActive` high, `ceOutN` stays low while `ceInN` stays low and fewer than `GRACE_TICKS` ticks have been counted. `ceOutN` goes high as soon as `ceInN` goes high.
- R5: Grace ticks are the clock edges after the entry edge at which `usTick` is high. After the edge that counts tick number `GRACE_TICKS`, `ceOutN` is high even though `ceInN` is still low.
- R6: Once the gate has closed during a reset, a later low on `ceInN` before reset ends does not reopen it.
- R7: After `rstN` is released with `resetActive` high (power-up), `ceOutN` stays high until `resetActive` falls, even if `ceInN` is low.
- R8: While `backupMode` is high, `ceOutN` is high in the same cycle, regardless of `ceInN` and `resetActive`.
- R9: When `resetActive` falls, from the grace window or from the closed state, `ceOutN` follows `ceInN` in that same cycle.
- R10: Each reset event gets its own full grace window. The tick count restarts at zero every time a new reset is first sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low register reset; the gate starts closed |
| ceInN | input | 1 | Incoming active-low chip-enable from the processor |
| resetActive | input | 1 | High while a system reset (supply or watchdog) is asserted |
| backupMode | input | 1 | High while running from the backup battery |
| usTick | input | 1 | One-cycle pulse every microsecond |
| ceOutN | output | 1 | Gated active-low chip-enable to the memory |

## Verification
Two ways of closing the grace window can land on the same clock edge. The processor can release the enable on the very edge that counts the final grace tick. Reset can also end on a tick edge partway through the window. The bench provokes the first case by raising `ceInN` and `usTick` together, one cycle after `GRACE_TICKS-1` ticks. It then judges that the gate is closed by lowering `ceInN` again and expecting a high output. It provokes the second case by dropping `resetActive` mid-window. It expects the output to follow the enable at once, and the next reset to receive a full window again.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;

  typedef enum logic [1:0] {
    GATE_OPEN  = 2'd0,
    GATE_GRACE = 2'd1,
    GATE_SHUT  = 2'd2
  } gateState_t;

  typedef struct packed {
    logic clearCount;
    logic countStep;
    logic passEnable;
  } gateStrobe_t;

endpackage

// File: rtl/ce_guard_ctrl.sv
module ce_guard_ctrl
  import ce_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceInN,
  input  logic        resetActive,
  input  logic        backupMode,
  input  logic        usTick,
  input  logic        graceLast,
  output gateStrobe_t strobes
);

  gateState_t gateState;
  gateState_t gateNext;

  always_comb begin
    gateNext = gateState;
    if (backupMode) begin
      gateNext = GATE_SHUT;
    end else begin
      unique case (gateState)
        GATE_OPEN: begin
          if (resetActive) gateNext = ceInN ? GATE_SHUT : GATE_GRACE;
        end
        GATE_GRACE: begin
          if (!resetActive)              gateNext = GATE_OPEN;
          else if (ceInN)                gateNext = GATE_SHUT;
          else if (usTick && graceLast)  gateNext = GATE_SHUT;
        end
        GATE_SHUT: begin
          if (!resetActive) gateNext = GATE_OPEN;
        end
        default: gateNext = GATE_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateState <= GATE_SHUT;
    else       gateState <= gateNext;
  end

  always_comb begin
    strobes.clearCount = (gateState == GATE_OPEN);
    strobes.countStep  = (gateState == GATE_GRACE) && usTick;
    strobes.passEnable = !backupMode && (!resetActive || gateState != GATE_SHUT);
  end

endmodule

// File: rtl/ce_guard_dp.sv
module ce_guard_dp
  import ce_guard_pkg::*;
#(
  parameter int GRACE_TICKS = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceInN,
  input  gateStrobe_t strobes,
  output logic        graceLast,
  output logic        ceOutN
);

  localparam int CNT_W = (GRACE_TICKS < 2) ? 1 : $clog2(GRACE_TICKS);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(GRACE_TICKS - 1);

  logic [CNT_W-1:0] graceCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  graceCnt <= '0;
    else if (strobes.clearCount) graceCnt <= '0;
    else if (strobes.countStep && graceCnt != LAST_VAL) graceCnt <= graceCnt + 1'b1;
  end

  assign graceLast = (graceCnt == LAST_VAL);
  assign ceOutN    = strobes.passEnable ? ceInN : 1'b1;

endmodule

// File: rtl/ce_guard_top.sv
module ce_guard_top
  import ce_guard_pkg::*;
#(
  parameter int GRACE_TICKS = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceInN,
  input  logic resetActive,
  input  logic backupMode,
  input  logic usTick,
  output logic ceOutN
);

  gateStrobe_t strobes;
  logic        graceLast;

  ce_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ceInN      (ceInN),
    .resetActive(resetActive),
    .backupMode (backupMode),
    .usTick     (usTick),
    .graceLast  (graceLast),
    .strobes    (strobes)
  );

  ce_guard_dp #(.GRACE_TICKS(GRACE_TICKS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ceInN    (ceInN),
    .strobes  (strobes),
    .graceLast(graceLast),
    .ceOutN   (ceOutN)
  );

endmodule

// File: rtl/ce_guard_chk.sv
module ce_guard_chk #(
  parameter int GRACE_TICKS = 15
) (
  input logic clk,
  input logic rstN,
  input logic ceInN,
  input logic resetActive,
  input logic backupMode,
  input logic usTick,
  input logic ceOutN
);

  localparam int CK_W = $clog2(GRACE_TICKS + 3);

  logic [CK_W-1:0] lowTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          lowTicks <= '0;
    else if (!resetActive || ceOutN)    lowTicks <= '0;
    else if (usTick && lowTicks != '1)  lowTicks <= lowTicks + 1'b1;
  end

  assert_follow_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!resetActive && !backupMode) |-> (ceOutN == ceInN));

  assert_low_needs_in_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ceOutN |-> !ceInN);

  // R3 and R6: enable high at an edge inside reset keeps the gate shut afterwards
  assert_stays_shut_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(resetActive) && $past(ceInN) && resetActive) |-> ceOutN);

  assert_grace_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resetActive && !ceOutN) |-> (lowTicks <= CK_W'(GRACE_TICKS)));

  assert_backup_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    backupMode |-> ceOutN);

endmodule

bind ce_guard_top ce_guard_chk #(.GRACE_TICKS(GRACE_TICKS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ceInN      (ceInN),
  .resetActive(resetActive),
  .backupMode (backupMode),
  .usTick     (usTick),
  .ceOutN     (ceOutN)
);

// File: tb/sim_ce_guard_top.sv
module sim_ce_guard_top;

  localparam int CLK_PERIOD = 10;
  localparam int GRACE = 15;

  logic clk = 1'b0;
  logic rstN, ceInN, resetActive, backupMode, usTick;
  logic ceOutN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ce_guard_top #(.GRACE_TICKS(GRACE)) u0 (
    .clk(clk), .rstN(rstN), .ceInN(ceInN), .resetActive(resetActive),
    .backupMode(backupMode), .usTick(usTick), .ceOutN(ceOutN)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (ceOutN !== exp) begin
      errors++;
      $display("FAIL %s: ceOutN=%b expected %b at %0t", req, ceOutN, exp, $time);
    end
  endtask

  // change inputs just after a falling edge, then look after settling
  task automatic setIn(input logic ce, input logic ra, input logic bk);
    @(negedge clk);
    ceInN = ce; resetActive = ra; backupMode = bk;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); usTick = 1'b1;
      @(negedge clk); usTick = 1'b0;
    end
    #1;
  endtask

  task automatic leaveReset();
    setIn(1'b1, 1'b0, 1'b0);
    idle(2);
  endtask

  task automatic t_powerUp();
    rstN = 1'b0; ceInN = 1'b0; resetActive = 1'b1; backupMode = 1'b0; usTick = 1'b0;
    idle(2);
    check("R7 reset state", 1'b1);
    @(negedge clk); rstN = 1'b1;
    idle(3);
    check("R7 power-up closed", 1'b1);
    setIn(1'b1, 1'b1, 1'b0);
    setIn(1'b0, 1'b1, 1'b0);
    check("R7 power-up ignores enable", 1'b1);
    setIn(1'b0, 1'b0, 1'b0);
    check("R9 release follows at once", 1'b0);
    idle(2);
  endtask

  task automatic t_pass();
    setIn(1'b1, 1'b0, 1'b0); check("R1 pass high", 1'b1);
    setIn(1'b0, 1'b0, 1'b0); check("R1 pass low", 1'b0);
    @(negedge clk); #2; ceInN = 1'b1; #1;
    check("R2 mid-cycle release", 1'b1);
    ceInN = 1'b0; #1;
    check("R1 combinational", 1'b0);
  endtask

  task automatic t_closeIdle();
    setIn(1'b1, 1'b1, 1'b0);
    idle(1);
    setIn(1'b0, 1'b1, 1'b0);
    check("R3 idle at reset closes", 1'b1);
    idle(5);
    check("R3 stays closed", 1'b1);
    leaveReset();
  endtask

  task automatic enterGrace();
    setIn(1'b0, 1'b0, 1'b0);
    setIn(1'b0, 1'b1, 1'b0);
    idle(1);
  endtask

  task automatic t_graceRelease();
    enterGrace();
    check("R4 access continues", 1'b0);
    ticks(3);
    check("R4 still low", 1'b0);
    setIn(1'b1, 1'b1, 1'b0);
    check("R4 release closes", 1'b1);
    setIn(1'b0, 1'b1, 1'b0);
    check("R6 no reopen", 1'b1);
    leaveReset();
  endtask

  task automatic t_graceExpire(input string tag);
    enterGrace();
    ticks(GRACE - 1);
    check({tag, " low before last tick"}, 1'b0);
    ticks(1);
    check({tag, " expired"}, 1'b1);
    idle(3);
    check("R6 stays closed after expiry", 1'b1);
  endtask

  task automatic t_fresh();
    t_graceExpire("R5");
    setIn(1'b0, 1'b0, 1'b0);
    check("R9 release from closed", 1'b0);
    idle(2);
    t_graceExpire("R10");
    leaveReset();
  endtask

  task automatic t_simul();
    enterGrace();
    ticks(GRACE - 1);
    @(negedge clk); usTick = 1'b1; ceInN = 1'b1;
    @(negedge clk); usTick = 1'b0; ceInN = 1'b0; #1;
    check("R6 tick and release together", 1'b1);
    leaveReset();
  endtask

  task automatic t_graceDeassert();
    enterGrace();
    ticks(GRACE / 2);
    setIn(1'b0, 1'b0, 1'b0);
    check("R9 release from grace", 1'b0);
    idle(2);
    enterGrace();
    ticks(GRACE - 1);
    check("R10 count restarted", 1'b0);
    ticks(1);
    check("R10 full window ends", 1'b1);
    leaveReset();
  endtask

  task automatic t_backup();
    setIn(1'b0, 1'b0, 1'b1);
    check("R8 backup forces high", 1'b1);
    setIn(1'b0, 1'b1, 1'b1);
    idle(2);
    check("R8 backup in reset", 1'b1);
    setIn(1'b0, 1'b0, 1'b0);
    check("R9 leave backup follows", 1'b0);
    idle(2);
  endtask

  initial begin
    t_powerUp();
    t_pass();
    t_closeIdle();
    t_graceRelease();
    t_fresh();
    t_simul();
    t_graceDeassert();
    t_backup();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule